// File: doc/BRIEF.md
# Dual-Stream Systolic FIR Filter

This block filters two independent sample streams at once with a single, shared set of integer tap weights. Each stream enters through its own valid/ready input. Each stream leaves through its own valid/ready output, which carries the unrounded sum of products. The arithmetic is a transposed systolic multiply-accumulate chain, one chain per stream. Each accepted sample is multiplied by every weight in the same cycle. The products ripple through a row of partial-sum registers, so a stage adds only one product to the registered sum of the stage next to it.

The weights are loaded at reset from a parameter vector. A plain write port can overwrite them one at a time. Both chains read the same weight registers. A sample takes the weights that are in force on the clock edge where it is accepted, so the weights can be changed while data flows and the result stays well defined. The filter runs at a single rate: every accepted input produces exactly one output.

Each stream has a one-entry output register, and the rules for back-pressure follow from it. An input is accepted on an edge where its valid is high and its ready is high. Ready is high whenever the output register is empty, or is being emptied in that same cycle. A result that is held while its output ready is low stays unchanged. Neither stream can stall the other.

Top module: `fir2_dual_top`

## Requirements
- R1: A synchronous reset sets both output valids low. It clears every partial-sum register to zero and loads tap weight k from bits [16k+15:16k] of the parameter `COEF_INIT`. The first output after reset therefore treats all earlier samples as zero.
- R2: For each stream, output number n equals the sum over k = 0..T-1 of b_k·x[n-k]. Here x[n] is the n-th sample accepted on that stream since reset, and samples before the first one count as zero.
- R3: The streams are independent. A stream's results depend only on samples accepted on that stream, and one stream's valid, ready or data never changes the other stream's results or timing.
- R4: A write with `coef_we` high sets tap weight `coef_addr` (0 = weight applied to the newest sample) to the two's-complement value `coef_wdata`. A sample accepted on the same edge still uses the old weight. Every sample accepted on a later edge is multiplied by the new weight, in every output that sample contributes to.
- R5: Results are full precision, in DW+16+ceil(log2 T) bits of signed two's complement, with no rounding, truncation or saturation. The extreme case is T samples of the most negative input against T weights of −32768.
- R6: A sample accepted on an edge produces its result with output valid high after that same edge. If no sample is accepted and the output ready is high, the output valid is low after the edge.
- R7: While output valid is high and output ready is low, the output data and valid hold, and input ready is low.
- R8: A cycle in which no sample is accepted leaves the partial sums unchanged, so idle gaps between samples do not alter any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Tap weight write strobe |
| coef_addr | input | AW = ceil(log2 TAPS) | Tap index being written |
| coef_wdata | input | CW | New signed tap weight |
| s0_valid | input | 1 | Stream 0 sample valid |
| s0_ready | output | 1 | Stream 0 can accept a sample |
| s0_data | input | DW | Stream 0 signed sample |
| s1_valid | input | 1 | Stream 1 sample valid |
| s1_ready | output | 1 | Stream 1 can accept a sample |
| s1_data | input | DW | Stream 1 signed sample |
| m0_valid | output | 1 | Stream 0 result valid |
| m0_ready | input | 1 | Stream 0 result taken |
| m0_data | output | OW | Stream 0 full-precision result |
| m1_valid | output | 1 | Stream 1 result valid |
| m1_ready | input | 1 | Stream 1 result taken |
| m1_data | output | OW | Stream 1 full-precision result |

## Verification
The hardest case to reach from the ports is a weight rewrite that lands while older samples of the same stream are still spread across the partial-sum registers, at a moment when the output is also stalled. The bench reaches it by running a weight-writer process concurrently with both streams while the output-ready patterns stall each stream on a different rhythm. The reference model stores each sample together with a snapshot of the weights in force when it was accepted. The test ends with a minimum-value burst, which drives the sum to exactly 2^32.

// File: rtl/fir2_pkg.sv
`timescale 1ns/1ps
package fir2_pkg;

  localparam int NPATH = 2;

  // Width that holds the largest possible sum of TAPS products.
  function automatic int sum_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/fir2_coef_bank.sv
`timescale 1ns/1ps
module fir2_coef_bank #(
  parameter int TAPS = 16,
  parameter int CW   = 16,
  parameter int AW   = 4,
  parameter logic [TAPS*CW-1:0] INIT = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [CW-1:0]            wdata,
  output logic [TAPS-1:0][CW-1:0]  coef_o
);

  logic [CW-1:0] creg [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic [AW-1:0] IDX = AW'(k);

    always_ff @(posedge clk) begin
      if (rst) begin
        creg[k] <= INIT[k*CW +: CW];
      end else if (we && addr == IDX) begin
        creg[k] <= wdata;
      end
    end

    assign coef_o[k] = creg[k];
  end

endmodule

// File: rtl/fir2_mac_chain.sv
`timescale 1ns/1ps
module fir2_mac_chain #(
  parameter int TAPS = 16,
  parameter int DW   = 14,
  parameter int CW   = 16,
  parameter int OW   = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic signed [DW-1:0]     x_i,
  input  logic [TAPS-1:0][CW-1:0]  coef_i,
  output logic signed [OW-1:0]     y_o
);

  // Every tap multiplies the newest sample; partial sums move toward tap 0.
  logic signed [OW-1:0] prod [TAPS];
  logic signed [OW-1:0] psum [1:TAPS-1];

  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    assign prod[k] = OW'($signed(x_i) * $signed(coef_i[k]));
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_stage
    if (k == TAPS - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) begin
          psum[k] <= '0;
        end else if (advance) begin
          psum[k] <= prod[k];
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) begin
          psum[k] <= '0;
        end else if (advance) begin
          psum[k] <= prod[k] + psum[k+1];
        end
      end
    end
  end

  assign y_o = prod[0] + psum[1];

endmodule

// File: rtl/fir2_out_stage.sv
`timescale 1ns/1ps
module fir2_out_stage #(
  parameter int OW = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [OW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] out_data,
  output logic                 accept
);

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fir2_dual_top.sv
`timescale 1ns/1ps
module fir2_dual_top #(
  parameter int TAPS = 16,
  parameter int DW   = 14,
  parameter int CW   = 16,
  parameter logic [TAPS*CW-1:0] COEF_INIT = '0,
  localparam int AW  = $clog2(TAPS),
  localparam int OW  = fir2_pkg::sum_width(DW, CW, TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_we,
  input  logic [AW-1:0]        coef_addr,
  input  logic [CW-1:0]        coef_wdata,
  input  logic                 s0_valid,
  output logic                 s0_ready,
  input  logic signed [DW-1:0] s0_data,
  input  logic                 s1_valid,
  output logic                 s1_ready,
  input  logic signed [DW-1:0] s1_data,
  output logic                 m0_valid,
  input  logic                 m0_ready,
  output logic signed [OW-1:0] m0_data,
  output logic                 m1_valid,
  input  logic                 m1_ready,
  output logic signed [OW-1:0] m1_data
);

  localparam int NP = fir2_pkg::NPATH;

  logic [TAPS-1:0][CW-1:0] coef;

  logic                 in_v   [NP];
  logic                 in_r   [NP];
  logic signed [DW-1:0] in_x   [NP];
  logic                 out_v  [NP];
  logic                 out_r  [NP];
  logic signed [OW-1:0] out_d  [NP];
  logic signed [OW-1:0] y_sum  [NP];
  logic                 adv    [NP];

  assign in_v[0]  = s0_valid;
  assign in_v[1]  = s1_valid;
  assign in_x[0]  = s0_data;
  assign in_x[1]  = s1_data;
  assign out_r[0] = m0_ready;
  assign out_r[1] = m1_ready;
  assign s0_ready = in_r[0];
  assign s1_ready = in_r[1];
  assign m0_valid = out_v[0];
  assign m1_valid = out_v[1];
  assign m0_data  = out_d[0];
  assign m1_data  = out_d[1];

  fir2_coef_bank #(
    .TAPS (TAPS),
    .CW   (CW),
    .AW   (AW),
    .INIT (COEF_INIT)
  ) u_coef (
    .clk    (clk),
    .rst    (rst),
    .we     (coef_we),
    .addr   (coef_addr),
    .wdata  (coef_wdata),
    .coef_o (coef)
  );

  for (genvar p = 0; p < NP; p++) begin : g_path
    fir2_mac_chain #(
      .TAPS (TAPS),
      .DW   (DW),
      .CW   (CW),
      .OW   (OW)
    ) u_chain (
      .clk     (clk),
      .rst     (rst),
      .advance (adv[p]),
      .x_i     (in_x[p]),
      .coef_i  (coef),
      .y_o     (y_sum[p])
    );

    fir2_out_stage #(
      .OW (OW)
    ) u_out (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_v[p]),
      .in_ready  (in_r[p]),
      .in_data   (y_sum[p]),
      .out_valid (out_v[p]),
      .out_ready (out_r[p]),
      .out_data  (out_d[p]),
      .accept    (adv[p])
    );
  end

endmodule

// File: rtl/fir2_dual_chk.sv
`timescale 1ns/1ps
module fir2_dual_chk #(
  parameter int OW = 34
) (
  input logic          clk,
  input logic          rst,
  input logic          s0_valid,
  input logic          s0_ready,
  input logic          s1_valid,
  input logic          s1_ready,
  input logic          m0_valid,
  input logic          m0_ready,
  input logic [OW-1:0] m0_data,
  input logic          m1_valid,
  input logic          m1_ready,
  input logic [OW-1:0] m1_data
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!m0_valid && !m1_valid));

  assert_hold_p0_R7: assert property (@(posedge clk) disable iff (rst)
    (m0_valid && !m0_ready) |=> (m0_valid && $stable(m0_data)));
  assert_hold_p1_R7: assert property (@(posedge clk) disable iff (rst)
    (m1_valid && !m1_ready) |=> (m1_valid && $stable(m1_data)));

  assert_block_p0_R7: assert property (@(posedge clk) disable iff (rst)
    (m0_valid && !m0_ready) |-> !s0_ready);
  assert_block_p1_R7: assert property (@(posedge clk) disable iff (rst)
    (m1_valid && !m1_ready) |-> !s1_ready);

  assert_latency_p0_R6: assert property (@(posedge clk) disable iff (rst)
    (s0_valid && s0_ready) |=> m0_valid);
  assert_latency_p1_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_ready) |=> m1_valid);

  assert_drain_p0_R6: assert property (@(posedge clk) disable iff (rst)
    (!(s0_valid && s0_ready) && m0_ready) |=> !m0_valid);
  assert_drain_p1_R6: assert property (@(posedge clk) disable iff (rst)
    (!(s1_valid && s1_ready) && m1_ready) |=> !m1_valid);

endmodule

bind fir2_dual_top fir2_dual_chk #(.OW(OW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .s0_valid (s0_valid),
  .s0_ready (s0_ready),
  .s1_valid (s1_valid),
  .s1_ready (s1_ready),
  .m0_valid (m0_valid),
  .m0_ready (m0_ready),
  .m0_data  (m0_data),
  .m1_valid (m1_valid),
  .m1_ready (m1_ready),
  .m1_data  (m1_data)
);

// File: tb/test_fir2_dual_top.sv
`timescale 1ns/1ps
module test_fir2_dual_top;

  localparam int TAPS = 16;
  localparam int DW   = 14;
  localparam int CW   = 16;
  localparam int AW   = 4;
  localparam int OW   = DW + CW + 4;

  function automatic longint init_w(input int k);
    return longint'(3 * k - 20);
  endfunction

  function automatic logic [TAPS*CW-1:0] mk_init();
    logic [TAPS*CW-1:0] v;
    v = '0;
    for (int k = 0; k < TAPS; k++) v[k*CW +: CW] = CW'(init_w(k));
    return v;
  endfunction

  localparam logic [TAPS*CW-1:0] INIT_P = mk_init();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_wdata = '0;
  logic                 s_valid [2];
  logic                 s_ready [2];
  logic signed [DW-1:0] s_data  [2];
  logic                 m_valid [2];
  logic                 m_ready [2];
  logic signed [OW-1:0] m_data  [2];

  always #10 clk = ~clk;

  fir2_dual_top #(
    .TAPS      (TAPS),
    .DW        (DW),
    .CW        (CW),
    .COEF_INIT (INIT_P)
  ) i_fir2_dual_top (
    .clk        (clk),
    .rst        (rst),
    .coef_we    (coef_we),
    .coef_addr  (coef_addr),
    .coef_wdata (coef_wdata),
    .s0_valid   (s_valid[0]),
    .s0_ready   (s_ready[0]),
    .s0_data    (s_data[0]),
    .s1_valid   (s_valid[1]),
    .s1_ready   (s_ready[1]),
    .s1_data    (s_data[1]),
    .m0_valid   (m_valid[0]),
    .m0_ready   (m_ready[0]),
    .m0_data    (m_data[0]),
    .m1_valid   (m_valid[1]),
    .m1_ready   (m_ready[1]),
    .m1_data    (m_data[1])
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  int rmode = 0;
  int cyc = 0;
  bit done = 0;

  longint cm [TAPS];
  longint hx [2][TAPS];
  longint hc [2][TAPS][TAPS];
  longint q0 [$];
  longint q1 [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic reset_model();
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < TAPS; k++) begin
        hx[p][k] = 0;
        for (int j = 0; j < TAPS; j++) hc[p][k][j] = 0;
      end
    for (int k = 0; k < TAPS; k++) cm[k] = init_w(k);
  endtask

  // Driver: offer one sample, wait for acceptance, push the expected result.
  task automatic send(input int p, input longint x, input int gap);
    longint e;
    s_data[p]  = DW'(x);
    s_valid[p] = 1'b1;
    #1;
    while (!s_ready[p]) begin
      @(negedge clk);
      #1;
    end
    for (int k = TAPS - 1; k > 0; k--) begin
      hx[p][k] = hx[p][k-1];
      hc[p][k] = hc[p][k-1];
    end
    hx[p][0] = x;
    hc[p][0] = cm;
    e = 0;
    for (int k = 0; k < TAPS; k++) e += hc[p][k][k] * hx[p][k];
    if (p == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    s_valid[p] = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  function automatic longint pick(input int mode, input int p, input int i);
    case (mode)
      0: return (i == 0) ? 1 : 0;
      1: return 0;
      2: return longint'((i * 7919 + p * 4099 + 17) % 16384) - 8192;
      3: return -8192;
      default: return 8191;
    endcase
  endfunction

  task automatic stream(input int p, input int n, input int mode, input int gapped);
    for (int i = 0; i < n; i++)
      send(p, pick(mode, p, i), (gapped != 0 && (i % 3 == 0)) ? 2 : 0);
  endtask

  task automatic write_w(input int a, input longint d);
    @(negedge clk);
    coef_we    = 1'b1;
    coef_addr  = AW'(a);
    coef_wdata = CW'(d);
    @(posedge clk);
    #1;
    cm[a] = d;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic drain();
    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Output-ready patterns
  initial begin
    m_ready[0] = 1'b1;
    m_ready[1] = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      m_ready[0] = (rmode == 0) ? 1'b1 : (cyc % 3 != 0);
      m_ready[1] = (rmode == 0) ? 1'b1 : (cyc % 4 < 2);
    end
  end

  // Monitor: scoreboard compare and stall-hold check
  initial begin
    bit held [2];
    longint hdat [2];
    held[0] = 0;
    held[1] = 0;
    hdat[0] = 0;
    hdat[1] = 0;
    forever begin
      @(negedge clk);
      #2;
      for (int p = 0; p < 2; p++) begin
        if (held[p] && m_valid[p])
          check(longint'(m_data[p]) == hdat[p], "R7", "held result changed",
                longint'(m_data[p]), hdat[p]);
        if (!rst && m_valid[p] && m_ready[p]) begin
          longint e;
          bit empty;
          empty = (p == 0) ? (q0.size() == 0) : (q1.size() == 0);
          if (empty) begin
            check(1'b0, cur_req, "unexpected result", longint'(m_data[p]), 0);
          end else begin
            e = (p == 0) ? q0.pop_front() : q1.pop_front();
            check(longint'(m_data[p]) == e, cur_req,
                  (p == 0) ? "stream 0 result" : "stream 1 result",
                  longint'(m_data[p]), e);
          end
        end
        held[p] = m_valid[p] && !m_ready[p];
        hdat[p] = longint'(m_data[p]);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    s_valid[0] = 1'b0;
    s_valid[1] = 1'b0;
    s_data[0]  = '0;
    s_data[1]  = '0;
    reset_model();
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    check(!m_valid[0] && !m_valid[1], "R1", "valid in reset", m_valid[0], 0);
    rst = 1'b0;
    @(negedge clk);
    check(s_ready[0] && s_ready[1], "R1", "ready after reset", s_ready[0], 1);
    check(!m_valid[1], "R1", "valid after reset", m_valid[1], 0);

    // R6: one sample, result valid right after acceptance, then gone
    cur_req = "R6";
    send(0, 5, 0);
    #1;
    check(m_valid[0] == 1'b1, "R6", "valid after accept", m_valid[0], 1);
    check(m_valid[1] == 1'b0, "R3", "other stream idle", m_valid[1], 0);
    @(negedge clk);
    #3;
    check(m_valid[0] == 1'b0, "R6", "valid after drain", m_valid[0], 0);
    drain();

    // R1/R2/R3: impulse through reset weights on stream 0, zeros on stream 1
    cur_req = "R2";
    fork
      stream(0, 20, 0, 0);
      stream(1, 20, 1, 0);
    join
    drain();

    // R8: varied data with idle gaps on stream 1, R7 with stalls
    cur_req = "R8";
    rmode = 1;
    fork
      stream(0, 40, 2, 0);
      stream(1, 40, 2, 1);
    join
    drain();

    // R4: weight rewrites while both streams flow under back-pressure
    cur_req = "R4";
    fork
      stream(0, 60, 2, 1);
      stream(1, 60, 2, 0);
      begin
        for (int k = 0; k < TAPS; k++) begin
          write_w(k, longint'((k * k * 37) % 2000) - 1000);
          repeat (2) @(negedge clk);
        end
      end
    join
    drain();
    rmode = 0;

    // R5: extreme magnitudes, final sum 2^32
    cur_req = "R5";
    for (int k = 0; k < TAPS; k++) write_w(k, -32768);
    fork
      stream(0, 20, 3, 0);
      stream(1, 20, 4, 0);
    join
    drain();

    // R1: reset mid-history restores weights and clears partial sums
    cur_req = "R1";
    fork
      stream(0, 5, 2, 0);
      stream(1, 5, 2, 0);
    join
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    q0.delete();
    q1.delete();
    reset_model();
    @(negedge clk);
    fork
      stream(0, 18, 1, 0);
      stream(1, 18, 0, 0);
    join
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule